// File: doc/BRIEF.md
# Indexed load/store address generator

This block forms the memory address and the updated base register value for a single load or store. It takes a base value and an offset. The offset is either a 12-bit unsigned immediate or a second register value passed through a shifter whose amount comes only from an immediate field. Control inputs select whether the offset is added or subtracted. They also select whether the address is formed before or after indexing, and whether the modified base is written back.

The results are registered. A request presented with `in_valid` high produces its address, new base, write-back enable and force-user flag on the outputs one clock later, together with `out_valid`. In post-indexed mode the base is always written back. In that mode the write-back bit is repurposed: when the core is privileged, it marks the access as non-privileged so that address translation treats it as a user access.

Top module: `ldst_agen`

## Requirements
- R1: While `rst_n` is low and after its release until the first request, `out_valid`, `addr_o`, `new_base_o`, `wb_en_o` and `force_user_o` are all zero.
- R2: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high, and the other outputs carry that request's results in the same cycle.
- R3: With `off_is_reg_i` = 0 the offset is `imm12_i` zero-extended to 32 bits.
- R4: With `off_is_reg_i` = 1 the offset is `reg_off_i` shifted by `shift_amt_i` (0 to 31). `shift_type_i` selects the shift: 0 logical left, 1 logical right, 2 arithmetic right, 3 rotate right. An amount of 0 leaves the value unchanged for every type.
- R5: `new_base_o` is base plus offset when `up_i` = 1 and base minus offset when `up_i` = 0, both modulo 2^32.
- R6: With `pre_i` = 1, `addr_o` equals `new_base_o`. With `pre_i` = 0, `addr_o` equals the unmodified base.
- R7: `wb_en_o` equals `wb_i` when `pre_i` = 1, and is always 1 when `pre_i` = 0.
- R8: `force_user_o` is 1 only when `pre_i` = 0, `wb_i` = 1 and `priv_i` = 1. It is 0 for every pre-indexed request and for every request from an unprivileged core.
- R9: In a cycle after one with `in_valid` low, `addr_o`, `new_base_o`, `wb_en_o` and `force_user_o` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present this cycle |
| base_i | input | 32 | Base register value |
| reg_off_i | input | 32 | Register offset value before shifting |
| imm12_i | input | 12 | Unsigned immediate offset |
| off_is_reg_i | input | 1 | 1 selects the shifted register offset, 0 the immediate |
| shift_type_i | input | 2 | Shift kind for the register offset |
| shift_amt_i | input | 5 | Immediate shift amount |
| up_i | input | 1 | 1 adds the offset, 0 subtracts it |
| pre_i | input | 1 | 1 pre-indexed, 0 post-indexed |
| wb_i | input | 1 | Write-back request, or user-access request in post-indexed mode |
| priv_i | input | 1 | Core is in a privileged mode |
| out_valid | output | 1 | Results below are valid |
| addr_o | output | 32 | Transfer address |
| new_base_o | output | 32 | Modified base value |
| wb_en_o | output | 1 | Write the modified base back |
| force_user_o | output | 1 | Treat the access as non-privileged |

## Verification
Every result of a request is due at the first clock edge after the edge that samples `in_valid`. The bench drives inputs on a falling edge, drops `in_valid` at the next falling edge and compares all four results at that point, which is one register after the request was sampled. One further idle cycle is then sampled at the next falling edge to confirm that `out_valid` has fallen and that the results are held. The sweep covers every shift kind, every shift amount and every combination of the four control bits, in both offset modes and with data chosen to wrap in both directions.

// File: rtl/ldst_agen_pkg.sv
package ldst_agen_pkg;
    typedef enum logic [1:0] {
        SH_LSL = 2'd0,
        SH_LSR = 2'd1,
        SH_ASR = 2'd2,
        SH_ROR = 2'd3
    } shift_kind_e;
endpackage

// File: rtl/ldst_agen_shifter.sv
module ldst_agen_shifter
    import ldst_agen_pkg::*;
#(
    parameter int DW = 32,
    localparam int AW = $clog2(DW)
) (
    input  logic [DW-1:0] data_i,
    input  shift_kind_e   kind_i,
    input  logic [AW-1:0] amt_i,
    output logic [DW-1:0] data_o
);
    logic [2*DW-1:0] rot_wide;

    always_comb begin
        rot_wide = {data_i, data_i} >> amt_i;
        unique case (kind_i)
            SH_LSL:  data_o = data_i << amt_i;
            SH_LSR:  data_o = data_i >> amt_i;
            SH_ASR:  data_o = DW'($signed(data_i) >>> amt_i);
            default: data_o = rot_wide[DW-1:0];
        endcase
    end
endmodule

// File: rtl/ldst_agen_offset.sv
module ldst_agen_offset #(
    parameter int DW    = 32,
    parameter int IMM_W = 12
) (
    input  logic [DW-1:0]    base_i,
    input  logic [IMM_W-1:0] imm_i,
    input  logic [DW-1:0]    shifted_i,
    input  logic             use_reg_i,
    input  logic             up_i,
    output logic [DW-1:0]    modified_o
);
    logic [DW-1:0] imm_ext;
    logic [DW-1:0] offset;

    generate
        if (DW > IMM_W) begin : g_zext
            assign imm_ext = {{(DW-IMM_W){1'b0}}, imm_i};
        end else begin : g_trunc
            assign imm_ext = imm_i[DW-1:0];
        end
    endgenerate

    always_comb begin
        offset     = use_reg_i ? shifted_i : imm_ext;
        modified_o = up_i ? (base_i + offset) : (base_i - offset);
    end
endmodule

// File: rtl/ldst_agen.sv
module ldst_agen
    import ldst_agen_pkg::*;
#(
    parameter int DW    = 32,
    parameter int IMM_W = 12,
    localparam int AW   = $clog2(DW)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [DW-1:0]    base_i,
    input  logic [DW-1:0]    reg_off_i,
    input  logic [IMM_W-1:0] imm12_i,
    input  logic             off_is_reg_i,
    input  logic [1:0]       shift_type_i,
    input  logic [AW-1:0]    shift_amt_i,
    input  logic             up_i,
    input  logic             pre_i,
    input  logic             wb_i,
    input  logic             priv_i,
    output logic             out_valid,
    output logic [DW-1:0]    addr_o,
    output logic [DW-1:0]    new_base_o,
    output logic             wb_en_o,
    output logic             force_user_o
);
    typedef struct packed {
        logic          vld;
        logic [DW-1:0] addr;
        logic [DW-1:0] nbase;
        logic          wben;
        logic          fuser;
    } stage_t;

    stage_t        st_d, st_q;
    logic [DW-1:0] shifted;
    logic [DW-1:0] modified;

    ldst_agen_shifter #(.DW(DW)) shifter_i (
        .data_i (reg_off_i),
        .kind_i (shift_kind_e'(shift_type_i)),
        .amt_i  (shift_amt_i),
        .data_o (shifted)
    );

    ldst_agen_offset #(.DW(DW), .IMM_W(IMM_W)) offset_i (
        .base_i     (base_i),
        .imm_i      (imm12_i),
        .shifted_i  (shifted),
        .use_reg_i  (off_is_reg_i),
        .up_i       (up_i),
        .modified_o (modified)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.nbase = modified;
            st_d.addr  = pre_i ? modified : base_i;
            st_d.wben  = pre_i ? wb_i : 1'b1;
            st_d.fuser = !pre_i && wb_i && priv_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid    = st_q.vld;
    assign addr_o       = st_q.addr;
    assign new_base_o   = st_q.nbase;
    assign wb_en_o      = st_q.wben;
    assign force_user_o = st_q.fuser;
endmodule

// File: rtl/ldst_agen_chk.sv
module ldst_agen_chk #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic [DW-1:0] base_i,
    input logic          pre_i,
    input logic          wb_i,
    input logic          priv_i,
    input logic          out_valid,
    input logic [DW-1:0] addr_o,
    input logic [DW-1:0] new_base_o,
    input logic          wb_en_o,
    input logic          force_user_o
);
    AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> out_valid);  // R2
    AST_VALID_FALL: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> !out_valid); // R2
    AST_PRE_ADDR:   assert property (@(posedge clk) disable iff (!rst_n) (in_valid && pre_i) |=> (addr_o == new_base_o)); // R6
    AST_POST_ADDR:  assert property (@(posedge clk) disable iff (!rst_n) (in_valid && !pre_i) |=> (addr_o == $past(base_i))); // R6
    AST_PRE_WB:     assert property (@(posedge clk) disable iff (!rst_n) (in_valid && pre_i) |=> (wb_en_o == $past(wb_i))); // R7
    AST_POST_WB:    assert property (@(posedge clk) disable iff (!rst_n) (in_valid && !pre_i) |=> wb_en_o); // R7
    AST_NO_USER_PRE:  assert property (@(posedge clk) disable iff (!rst_n) (in_valid && pre_i) |=> !force_user_o); // R8
    AST_NO_USER_UNPR: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && !priv_i) |=> !force_user_o); // R8
    AST_HOLD_ADDR:  assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> ($stable(addr_o) && $stable(new_base_o))); // R9
endmodule

bind ldst_agen ldst_agen_chk #(.DW(DW)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .base_i       (base_i),
    .pre_i        (pre_i),
    .wb_i         (wb_i),
    .priv_i       (priv_i),
    .out_valid    (out_valid),
    .addr_o       (addr_o),
    .new_base_o   (new_base_o),
    .wb_en_o      (wb_en_o),
    .force_user_o (force_user_o)
);

// File: tb/ldst_agen_tb_top.sv
`timescale 1ns/1ps
module ldst_agen_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] base_i = '0;
    logic [31:0] reg_off_i = '0;
    logic [11:0] imm12_i = '0;
    logic        off_is_reg_i = 1'b0;
    logic [1:0]  shift_type_i = '0;
    logic [4:0]  shift_amt_i = '0;
    logic        up_i = 1'b0, pre_i = 1'b0, wb_i = 1'b0, priv_i = 1'b0;
    logic        out_valid;
    logic [31:0] addr_o, new_base_o;
    logic        wb_en_o, force_user_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    ldst_agen dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .base_i(base_i),
        .reg_off_i(reg_off_i), .imm12_i(imm12_i), .off_is_reg_i(off_is_reg_i),
        .shift_type_i(shift_type_i), .shift_amt_i(shift_amt_i), .up_i(up_i),
        .pre_i(pre_i), .wb_i(wb_i), .priv_i(priv_i), .out_valid(out_valid),
        .addr_o(addr_o), .new_base_o(new_base_o), .wb_en_o(wb_en_o),
        .force_user_o(force_user_o)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] model_shift(logic [31:0] x, int kind, int amt);
        logic [63:0] w;
        case (kind)
            0: return x * (32'd1 << amt);
            1: return x / (32'd1 << amt);
            2: begin
                w = {{32{x[31]}}, x};
                w = w / (64'd1 << amt);
                return w[31:0];
            end
            default: return (amt == 0) ? x : ((x >> amt) | (x << (32 - amt)));
        endcase
    endfunction

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        #(4 * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [31:0] bases [2];
        logic [31:0] regs  [2];
        logic [11:0] imms  [2];
        logic [31:0] offs, nb, prev_addr, prev_nb;
        string       tag;
        bases = '{32'h8000_0F10, 32'h0000_0004};
        regs  = '{32'hF0F0_1234, 32'h8000_0001};
        imms  = '{12'h5A3, 12'hFFF};

        repeat (3) @(negedge clk);
        check("R1", "out_valid in reset", {31'b0, out_valid}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "out_valid", {31'b0, out_valid}, 0);
        check("R1", "addr_o", addr_o, 0);
        check("R1", "new_base_o", new_base_o, 0);
        check("R1", "flags", {30'b0, wb_en_o, force_user_o}, 0);

        for (int mode = 0; mode < 2; mode++)
        for (int d = 0; d < 2; d++)
        for (int fl = 0; fl < 16; fl++)
        for (int k = 0; k < 4; k++)
        for (int a = 0; a < 32; a++) begin
            base_i       = bases[d];
            reg_off_i    = regs[d];
            imm12_i      = imms[d];
            off_is_reg_i = mode[0];
            shift_type_i = 2'(k);
            shift_amt_i  = 5'(a);
            {up_i, pre_i, wb_i, priv_i} = 4'(fl);
            in_valid = 1'b1;
            @(negedge clk);
            in_valid = 1'b0;
            offs = mode ? model_shift(regs[d], k, a) : {20'b0, imms[d]};
            nb   = up_i ? bases[d] + offs : bases[d] - offs;
            tag  = mode ? "R4" : (up_i ? "R3" : "R5");
            check("R2", "out_valid", {31'b0, out_valid}, 1);
            check(tag, "new_base_o", new_base_o, nb);
            check("R6", "addr_o", addr_o, pre_i ? nb : bases[d]);
            check("R7", "wb_en_o", {31'b0, wb_en_o}, {31'b0, (pre_i ? wb_i : 1'b1)});
            check("R8", "force_user_o", {31'b0, force_user_o},
                  {31'b0, (!pre_i && wb_i && priv_i)});
            prev_addr = addr_o;
            prev_nb   = new_base_o;
            base_i    = ~base_i;
            reg_off_i = ~reg_off_i;
            pre_i     = ~pre_i;
            @(negedge clk);
            check("R2", "out_valid idle", {31'b0, out_valid}, 0);
            check("R9", "addr_o hold", addr_o, prev_addr);
            check("R9", "new_base_o hold", new_base_o, prev_nb);
        end
        finish_run();
    end
endmodule